// File: doc/BRIEF.md
# Fractional microsecond timebase counter

This block keeps a free-running microsecond count that is clocked directly from a reference oscillator of any frequency. A rational prescaler turns the oscillator rate into the 1 MHz tick. Software programs the prescaler as a ratio of two small integers. The ratio is chosen so that reference rate × numerator / denominator equals 1 MHz. Rates such as 19.2 MHz (ratio 5/96) therefore give exact ticks with no long-term drift.

A small register port, with valid, write, address and data signals, reads the count and reads or writes the ratio. Delay loops compare the count against a target. A deadline input and a due flag do that comparison in hardware. The flag uses the sign of the modular difference, so it stays correct when the count wraps.

Top module: `usec_timebase`

## Requirements
- R1: The ratio register at offset 0x04 holds the denominator minus one in bits [7:0] and the numerator minus one in bits [15:8]. Writes ignore bits [31:16], and reads return zero in those bits.
- R2: When the numerator is no larger than the denominator, the count grows by floor(N × num / den) over the N clock edges that follow a ratio write. The internal remainder stays below the denominator. Examples: 0x000B gives 1/12, 0x045F gives 5/96 and 0x0203 gives 3/4.
- R3: A ratio value of zero gives 1/1, and the count then grows by one on every clock edge.
- R4: When the numerator exceeds the denominator, the rate saturates and the count grows by one on every clock edge.
- R5: The count reads at offset 0x00 and is read-only, so writes to it change neither the count nor the ratio. The count grows by 0 or 1 per edge and wraps modulo 2^CNT_W.
- R6: On the edge that writes the ratio register, the count does not change and the fractional remainder is cleared.
- R7: due_o is high exactly when the CNT_W-bit difference (count − deadline_i), read as a signed number, is zero or positive.
- R8: While rst_ni is low, the count, the remainder and the ratio register are all zero.
- R9: rdata_o is zero when req_i is low, when we_i is high, or when the address is neither 0x00 nor 0x04. A read of a mapped register returns its value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| deadline_i | input | CNT_W | Target count for the due comparison |
| due_o | output | 1 | Count has reached or passed the deadline |

## Verification
Some rules are checked on every cycle:
- the count never jumps by more than one;
- a ratio write never moves the count;
- the remainder stays below the denominator;
- unity and over-unity ratios step on every edge;
- the due flag agrees with equality and with the value one below it;
- an idle bus reads zero.

Other behaviour only shows over many cycles, so the bench scenarios have to show it:
- the exact long-run tick count for each ratio;
- the loss of a partial remainder when the ratio is rewritten;
- wrap-around on a narrow counter;
- the signed window limits of the due flag.

// File: rtl/utb_pkg.sv
`timescale 1ns/1ps
package utb_pkg;
  localparam int unsigned OFS_CNT = 32'h00;
  localparam int unsigned OFS_CFG = 32'h04;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CFG  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/utb_regs.sv
`timescale 1ns/1ps
module utb_regs
  import utb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [FIELD_W:0]   num_o,
  output logic [FIELD_W:0]   den_o,
  output logic               cfg_wr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int CFG_W = 2 * FIELD_W;
  localparam int ACC_W = FIELD_W + 1;

  reg_sel_e          sel;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] cfg_ext;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_CNT))      sel = SEL_CNT;
    else if (addr_i == ADDR_W'(OFS_CFG)) sel = SEL_CFG;
    else                                 sel = SEL_NONE;
  end

  assign cfg_wr_o = req_i && we_i && (sel == SEL_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_wr_o) cfg_q <= wdata_i[CFG_W-1:0];
  end

  // stored minus one
  assign den_o = ACC_W'(cfg_q[FIELD_W-1:0]) + ACC_W'(1);
  assign num_o = ACC_W'(cfg_q[CFG_W-1:FIELD_W]) + ACC_W'(1);

  generate
    if (CNT_W < DATA_W) begin : g_cnt_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
    end else begin : g_cnt_full
      assign cnt_ext = cnt_i[DATA_W-1:0];
    end
    if (CFG_W < DATA_W) begin : g_cfg_pad
      assign cfg_ext = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
    end else begin : g_cfg_full
      assign cfg_ext = cfg_q[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (sel)
        SEL_CNT: rdata_o = cnt_ext;
        SEL_CFG: rdata_o = cfg_ext;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/utb_frac.sv
`timescale 1ns/1ps
module utb_frac #(
  parameter int FIELD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [FIELD_W:0] num_i,
  input  logic [FIELD_W:0] den_i,
  output logic             tick_o,
  output logic [FIELD_W:0] acc_o
);
  localparam int ACC_W = FIELD_W + 1;
  localparam int SUM_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum, rem;
  logic             over, hit;

  always_comb begin
    sum  = SUM_W'(acc_q) + SUM_W'(num_i);
    rem  = sum - SUM_W'(den_i);
    over = num_i > den_i;
    hit  = sum >= SUM_W'(den_i);
    tick_o = !clr_i && (over || hit);
    if (clr_i || over) acc_d = '0;
    else if (hit)      acc_d = rem[ACC_W-1:0];
    else               acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/utb_count.sv
`timescale 1ns/1ps
module utb_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] deadline_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             due_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  // modular difference, sign bit decides
  assign gap   = cnt_q - deadline_i;
  assign due_o = !gap[CNT_W-1];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/usec_timebase.sv
`timescale 1ns/1ps
module usec_timebase #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int FIELD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  deadline_i,
  output logic              due_o
);
  logic [CNT_W-1:0] cnt_w;
  logic [FIELD_W:0] num_w, den_w, acc_w;
  logic             cfg_wr_w, tick_w;

  utb_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FIELD_W(FIELD_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt_w),
    .num_o(num_w), .den_o(den_w), .cfg_wr_o(cfg_wr_w), .rdata_o(rdata_o)
  );

  utb_frac #(.FIELD_W(FIELD_W)) u_frac (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cfg_wr_w),
    .num_i(num_w), .den_i(den_w), .tick_o(tick_w), .acc_o(acc_w)
  );

  utb_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w),
    .deadline_i(deadline_i), .cnt_o(cnt_w), .due_o(due_o)
  );
endmodule

// File: rtl/utb_chk.sv
`timescale 1ns/1ps
module utb_chk
  import utb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int FIELD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [CNT_W-1:0]  deadline_i,
  input logic              due_o,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [FIELD_W:0]  num_w,
  input logic [FIELD_W:0]  den_w,
  input logic [FIELD_W:0]  acc_w
);
  logic wr_cfg, wr_cnt;
  assign wr_cfg = req_i && we_i && (addr_i == ADDR_W'(OFS_CFG));
  assign wr_cnt = req_i && we_i && (addr_i == ADDR_W'(OFS_CNT));

  a_r2_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_w <= den_w) |-> (acc_w < den_w));

  a_r3_unity_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_w == den_w && !wr_cfg) |=> (cnt_w == CNT_W'($past(cnt_w) + 1'b1)));

  a_r4_over_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_w > den_w && !wr_cfg) |=> (cnt_w == CNT_W'($past(cnt_w) + 1'b1)));

  a_r5_step_le_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(cnt_w) || cnt_w == CNT_W'($past(cnt_w) + 1'b1)));

  a_r5_cnt_write_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> ($stable(num_w) && $stable(den_w)));

  a_r6_cfg_write_holds_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> $stable(cnt_w));

  a_r7_due_at_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == deadline_i) |-> due_o);

  a_r7_not_due_one_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CNT_W'(cnt_w + 1'b1) == deadline_i) |-> !due_o);

  a_r9_idle_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0));
endmodule

bind usec_timebase utb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .deadline_i(deadline_i),
  .due_o(due_o), .cnt_w(cnt_w), .num_w(num_w), .den_w(den_w), .acc_w(acc_w)
);

// File: tb/sim_usec_timebase.sv
`timescale 1ns/1ps
module sim_usec_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, dl = '0;
  logic        due;
  logic        req1 = 1'b0;
  logic [7:0]  addr1 = '0, dl1 = '0;
  logic [31:0] rdata1;
  logic        due1;
  logic [31:0] cyc;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;
  end

  usec_timebase u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .deadline_i(dl), .due_o(due)
  );

  usec_timebase #(.CNT_W(8)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .we_i(1'b0), .addr_i(addr1),
    .wdata_i(32'h0), .rdata_o(rdata1), .deadline_i(dl1), .due_o(due1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    req = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata;
    req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd1(output logic [31:0] v);
    req1 = 1'b1; addr1 = 8'h00;
    #1 v = rdata1;
    req1 = 1'b0;
  endtask

  task automatic run_ratio(input string tag, input logic [31:0] cfg, input int n);
    logic [31:0] s, e, got;
    longint num, den, inc;
    num = ((cfg >> 8) & 32'hFF) + 1;
    den = (cfg & 32'hFF) + 1;
    inc = (num > den) ? n : (n * num) / den;
    rd(8'h00, s);
    wr(8'h04, cfg);
    repeat (n) @(negedge clk);
    rd(8'h00, e);
    chk(tag, e - s, 32'(inc));
    rd(8'h04, got);
    chk("R1 cfg readback", got, cfg & 32'hFFFF);
  endtask

  task automatic due_at(input string tag, input logic [31:0] d, input logic exp);
    dl = d;
    #1 chk(tag, {31'b0, due}, {31'b0, exp});
  endtask

  initial begin
    logic [31:0] v, s, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    rd(8'h00, v); chk("R8 count after reset", v, 0);
    rd(8'h04, v); chk("R8 cfg after reset", v, 0);
    due_at("R7 due at zero", 32'h0, 1'b1);
    // R9 decode
    rd(8'h08, v); chk("R9 unmapped read", v, 0);
    #1 chk("R9 idle bus", rdata, 0);

    run_ratio("R2 12MHz 1/12", 32'h0000_000B, 120);
    run_ratio("R2 12MHz partial", 32'h0000_000B, 125);
    run_ratio("R2 13MHz 1/13", 32'h0000_000C, 131);
    run_ratio("R2 26MHz 1/26", 32'h0000_0019, 100);
    run_ratio("R2 19.2MHz 5/96", 32'h0000_045F, 960);
    run_ratio("R2 19.2MHz partial", 32'h0000_045F, 211);
    run_ratio("R2 3/4", 32'h0000_0203, 37);
    run_ratio("R1 upper bits ignored", 32'hABCD_0001, 40);
    run_ratio("R3 unity", 32'h0000_0000, 64);
    run_ratio("R4 over unity 2/1", 32'h0000_0100, 50);
    run_ratio("R4 over unity 256/255", 32'h0000_FFFE, 33);

    // R6 remainder cleared by rewrite
    wr(8'h04, 32'h0000_000B);
    repeat (5) @(negedge clk);
    rd(8'h00, s);
    wr(8'h04, 32'h0000_000B);
    repeat (11) @(negedge clk);
    rd(8'h00, v); chk("R6 remainder cleared", v, s);
    // R6 no step on write edge at unity
    wr(8'h04, 32'h0);
    rd(8'h00, s);
    wr(8'h04, 32'h0);
    rd(8'h00, v); chk("R6 count held on cfg write", v, s);

    // R5 count is read-only
    wr(8'h04, 32'h0000_000B);
    rd(8'h00, s);
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, v); chk("R5 count write ignored", v, s);
    rd(8'h04, v); chk("R5 cfg kept on count write", v, 32'h0000_000B);

    // R7 signed window, count frozen within this phase
    rd(8'h00, c);
    due_at("R7 equal", c, 1'b1);
    due_at("R7 one ahead", c + 1, 1'b0);
    due_at("R7 one behind", c - 1, 1'b1);
    due_at("R7 half range ahead", c + 32'h8000_0000, 1'b0);
    due_at("R7 max ahead", c + 32'h7FFF_FFFF, 1'b0);
    due_at("R7 max behind", c - 32'h7FFF_FFFF, 1'b1);
    due_at("R7 deadline across wrap", c - 32'h10, 1'b1);

    // R5 wrap on narrow counter (unity ratio after reset)
    rd1(v); chk("R5 narrow count wraps", v, cyc & 32'hFF);
    dl1 = 8'(v - 1);
    #1 chk("R7 narrow due behind", {31'b0, due1}, 32'd1);
    dl1 = 8'(v + 1);
    #1 chk("R7 narrow not due ahead", {31'b0, due1}, 32'd0);
    dl1 = 8'(v + 8'h80);
    #1 chk("R7 narrow half range", {31'b0, due1}, 32'd0);
    repeat (300) @(negedge clk);
    rd1(v); chk("R5 narrow count after wrap", v, cyc & 32'hFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule